// File: doc/BRIEF.md
# Two-Entry Shifting Queue

This block is a first-in, first-out buffer of exactly two entries with a parameterised data width. It has two storage registers, a front one and a back one, and each register has its own occupancy flag. The oldest entry is always held in the front register, so the head value drives the output straight from a flop, with no read multiplexer and no pointer.

A producer loads a word by raising `push` with `push_data`. A consumer removes the head by raising `pop`, and it reads the head from `head_data` while `has_data` is high. When a pop removes the head while a second entry is stored, the back entry moves into the front register. A push and a pop may arrive in the same cycle. A request that cannot be served is dropped: a push while full, or a pop while empty.

Top module: `two_slot_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both occupancy flags clear, so after that edge `has_data` is 0, `can_push` is 1 and `head_data` is 0.
- R2: `has_data` is 1 exactly when one or two entries are stored, and `can_push` is 0 exactly when two entries are stored.
- R3: A push into an empty queue (with or without a pop) makes `head_data` equal the pushed word one cycle later, with one entry stored.
- R4: A push without a pop while one entry is stored fills the back register: `head_data` stays unchanged and `can_push` drops to 0.
- R5: A pop while two entries are stored moves the back entry to the front: `head_data` becomes the second-oldest word and one entry remains.
- R6: A pop without a push while one entry is stored empties the queue.
- R7: A push and a pop together while one entry is stored replace the head with the pushed word, and exactly one entry remains.
- R8: A push and a pop together while two entries are stored perform only the pop; the pushed word is lost.
- R9: A push while full and without a pop is ignored: `head_data` and both flags keep their values.
- R10: A pop while empty and without a push is ignored: the queue stays empty.
- R11: Under any stream of requests, words leave in the order in which they were accepted, and `head_data` always shows the oldest stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Request to append `push_data` |
| push_data | input | WIDTH | Word to append |
| pop | input | 1 | Request to remove the head entry |
| head_data | output | WIDTH | Contents of the front register (the oldest entry) |
| has_data | output | 1 | At least one entry is stored |
| can_push | output | 1 | Back register is free |

## Verification
A push and a pop can arrive in the same cycle. The result depends on how many entries are stored at that moment. The bench raises both requests at once when the queue is empty, holds one entry and holds two entries. In each case it compares the next-cycle flags and head word with a queue model that accepts a push only below two entries and a pop only above zero. A long pseudo-random stream with both requests frequently high then checks that words still leave in their order of arrival.

// File: rtl/two_slot_fifo_pkg.sv
// Shared types for the two-entry shifting queue.
package two_slot_fifo_pkg;
    // Source that loads the front data register in a cycle
    typedef enum logic [1:0] {
        FRONT_HOLD = 2'd0,
        FRONT_FROM_INPUT = 2'd1,
        FRONT_FROM_BACK = 2'd2
    } front_src_e;
endpackage

// File: rtl/two_slot_fifo_slot.sv
// One storage slot: a data register with a load enable and an
// occupancy flag that is rewritten every cycle.
// Assumes a synchronous, active-low reset. The reset clears the flag
// and the data.
module two_slot_fifo_slot #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    input  logic             valid_nxt,
    output logic [WIDTH-1:0] q,
    output logic             valid
);
    // Register the data on load and the flag on every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            valid <= 1'b0;
        end else begin
            if (load) q <= d;
            valid <= valid_nxt;
        end
    end
endmodule

// File: rtl/two_slot_fifo_ctrl.sv
// Next-state control for the two slots. It accepts a push only while
// the back slot is free and a pop only while the front slot holds
// data. It decides what loads each slot.
// Assumes that the front slot is always filled before the back slot.
module two_slot_fifo_ctrl
    import two_slot_fifo_pkg::*;
(
    input  logic       push,
    input  logic       pop,
    input  logic       front_valid,
    input  logic       back_valid,
    output front_src_e front_src,
    output logic       front_valid_nxt,
    output logic       back_load,
    output logic       back_valid_nxt
);
    logic push_ok;
    logic pop_ok;

    // Qualify the requests against the occupancy
    always_comb begin
        push_ok = push && !back_valid;
        pop_ok  = pop && front_valid;
    end

    // Choose the slot updates for this cycle
    always_comb begin
        front_src       = FRONT_HOLD;
        front_valid_nxt = front_valid;
        back_load       = 1'b0;
        back_valid_nxt  = back_valid;
        if (pop_ok) begin
            if (back_valid) begin
                front_src      = FRONT_FROM_BACK;
                back_valid_nxt = 1'b0;
            end else if (push_ok) begin
                front_src = FRONT_FROM_INPUT;
            end else begin
                front_valid_nxt = 1'b0;
            end
        end else if (push_ok) begin
            if (front_valid) begin
                back_load      = 1'b1;
                back_valid_nxt = 1'b1;
            end else begin
                front_src       = FRONT_FROM_INPUT;
                front_valid_nxt = 1'b1;
            end
        end
    end
endmodule

// File: rtl/two_slot_fifo.sv
// Two-entry FIFO built as a front and a back register. The head is
// always in the front register. A pop moves the back entry forward.
// A push fills the first free slot.
// Assumes a synchronous, active-low reset. Requests that cannot be
// served are dropped.
module two_slot_fifo
    import two_slot_fifo_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             has_data,
    output logic             can_push
);
    localparam int SLOTS = 2;

    front_src_e       front_src;
    logic [SLOTS-1:0] valid_q;
    logic [SLOTS-1:0] valid_nxt;
    logic [SLOTS-1:0] load;
    logic [WIDTH-1:0] slot_d [SLOTS];
    logic [WIDTH-1:0] slot_q [SLOTS];

    two_slot_fifo_ctrl u_ctrl (
        .push            (push),
        .pop             (pop),
        .front_valid     (valid_q[0]),
        .back_valid      (valid_q[1]),
        .front_src       (front_src),
        .front_valid_nxt (valid_nxt[0]),
        .back_load       (load[1]),
        .back_valid_nxt  (valid_nxt[1])
    );

    // Select the front load source and the back input
    always_comb begin
        load[0]   = (front_src != FRONT_HOLD);
        slot_d[0] = (front_src == FRONT_FROM_BACK) ? slot_q[1] : push_data;
        slot_d[1] = push_data;
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        two_slot_fifo_slot #(.WIDTH(WIDTH)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[i]),
            .d         (slot_d[i]),
            .valid_nxt (valid_nxt[i]),
            .q         (slot_q[i]),
            .valid     (valid_q[i])
        );
    end

    // Drive the outputs from the slot state
    always_comb begin
        head_data = slot_q[0];
        has_data  = valid_q[0];
        can_push  = !valid_q[1];
    end
endmodule

// File: rtl/two_slot_fifo_chk.sv
// Checker for the two-entry queue, watching only the ports.
// Assumes that it is attached to every instance through the bind below.
module two_slot_fifo_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic [WIDTH-1:0] push_data,
    input logic             pop,
    input logic [WIDTH-1:0] head_data,
    input logic             has_data,
    input logic             can_push
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (!has_data && can_push));

    // R2
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !can_push |-> has_data);

    // R3
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_data && push) |=> (has_data && can_push && head_data == $past(push_data)));

    // R4
    back_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_data && can_push && push && !pop) |=> (!can_push && $stable(head_data)));

    // R5
    shift_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!can_push && pop) |=> (has_data && can_push));

    // R6
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_data && can_push && pop && !push) |=> !has_data);

    // R7
    replace_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_data && can_push && push && pop) |=> (has_data && can_push && head_data == $past(push_data)));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!can_push && push && !pop) |=> (!can_push && $stable(head_data)));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!has_data && pop && !push) |=> !has_data);

    // R11
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_data && !pop) |=> (has_data && $stable(head_data)));
endmodule

bind two_slot_fifo two_slot_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head_data (head_data),
    .has_data  (has_data),
    .can_push  (can_push)
);

// File: tb/two_slot_fifo_test.sv
// Scoreboard bench: the driver mirrors accepted pushes into a model
// queue, and the monitor compares each accepted pop and the settled
// state with it.
module two_slot_fifo_test;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push = 1'b0;
    logic             pop = 1'b0;
    logic [WIDTH-1:0] push_data = '0;
    logic [WIDTH-1:0] head_data;
    logic             has_data;
    logic             can_push;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] model [$];
    logic [15:0] lfsr = 16'hACE1;

    two_slot_fifo #(.WIDTH(WIDTH)) uut (
        .clk (clk), .rst_n (rst_n), .push (push), .push_data (push_data),
        .pop (pop), .head_data (head_data), .has_data (has_data),
        .can_push (can_push)
    );

    always #5 clk = ~clk;

    // Record one comparison and report a mismatch
    task automatic check(input string req, input string what,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare the flags and the head with the model
    task automatic check_state(input string req);
        check(req, "has_data", WIDTH'(has_data), WIDTH'(model.size() > 0));
        check(req, "can_push", WIDTH'(can_push), WIDTH'(model.size() < 2));
        if (model.size() > 0) check(req, "head_data", head_data, model[0]);
    endtask

    // Driver: apply one cycle of requests and update the model
    task automatic step(input logic p, input logic q, input logic [WIDTH-1:0] d,
                        input string req);
        bit push_ok;
        bit pop_ok;
        push = p; pop = q; push_data = d;
        push_ok = p && (model.size() < 2);
        pop_ok  = q && (model.size() > 0);
        if (pop_ok) check("R11", "popped word", head_data, model[0]);
        @(posedge clk);
        if (pop_ok) void'(model.pop_front());
        if (push_ok) model.push_back(d);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        check_state(req);
    endtask

    // Watchdog: treat a hung run as one failed check
    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus sequence
    initial begin
        repeat (3) @(negedge clk);
        check_state("R1");
        check("R1", "head_data after reset", head_data, '0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 16'h0, "R10");      // pop while empty
        step(1'b1, 1'b0, 16'h1111, "R3");    // push into empty
        step(1'b1, 1'b0, 16'h2222, "R4");    // push onto one entry
        step(1'b1, 1'b0, 16'h3333, "R9");    // push while full
        step(1'b1, 1'b1, 16'h4444, "R8");    // push and pop while full
        step(1'b1, 1'b1, 16'h5555, "R7");    // push and pop with one entry
        step(1'b1, 1'b0, 16'h6666, "R2");    // fill
        step(1'b0, 1'b1, 16'h0, "R5");       // pop with two
        step(1'b0, 1'b1, 16'h0, "R6");       // drain
        step(1'b1, 1'b1, 16'h7777, "R3");    // push and pop while empty
        step(1'b0, 1'b1, 16'h0, "R6");
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[3] | lfsr[5], WIDTH'(i * 7 + 3), "R11");
        end
        rst_n = 1'b0;
        model.delete();
        @(negedge clk);
        check_state("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule